// File: doc/BRIEF.md
# Code-Memory Byte Programming Sequencer

This block controls the programming port of an on-chip code store. A programmer presents an address, a data byte and a two-bit command, holds the high-voltage enable level, and raises the program strobe. A byte write or a protection-bit write is then timed internally by a cycle counter. While it runs, an active-low ready/busy output stays low. When the counter expires, the byte is committed to the array, which is modelled as a synchronous RAM that starts out erased to all ones.

Reads go through a two-stage pipeline. They return array data, a polling byte for the address still being written, a fixed identification byte, or an all-ones value when readback is locked. Three protection bits are sticky and survive reset. Their effect is cumulative: the first blocks further writes, latches the external-access input at reset and withdraws permission for externally fetched code to read internal code. The second adds a block on readback. The third adds a block on external execution. The bits are never returned on a read port; they are visible only through these effects.

Top module: `fprog_seq`

## Requirements
- R1: A rising edge on `pgm_stb` with `cmd`=00 (write byte), `hv_en` high, `busy_n` high and protection bit 1 clear starts a write. `busy_n` is low from the next cycle for exactly WR_CYCLES cycles, then returns high, and the byte is stored at `addr`.
- R2: A cycle with `rd_stb` high and `cmd`=01 (read byte) or 11 (signature) yields exactly one `rdata_vld` pulse two cycles later. For a read-byte command with no write pending and readback allowed, `rdata` holds the array byte at `addr`, and an unwritten location reads FFh.
- R3: During a byte write, a read of the address being written returns the written byte with bit 7 inverted and bits 6:0 true. After completion, the true byte is returned.
- R4: A strobe that arrives while `busy_n` is low is ignored. The running operation keeps its length and the ignored byte is not stored.
- R5: With `hv_en` low, neither a write-byte nor a protection-write command (`cmd`=10) starts. `busy_n` stays high and neither the array nor the protection state changes.
- R6: Once protection bit 1 is set, write-byte commands are ignored and `movc_ok` is low. While bit 1 is set, `ea_eff` holds the value `ea_pin` had during the last reset. While bit 1 is clear, `ea_eff` follows `ea_pin` one cycle later.
- R7: With protection bits 1 and 2 both set, a read-byte command returns FFh. With bit 2 alone set, reads are unaffected.
- R8: With all three protection bits set, `ext_exec_ok` is low. It is never low while `movc_ok` is high.
- R9: A signature read (`cmd`=11) of address 030h, 031h or 032h returns 1Eh, 87h or 02h respectively. Any other address returns FFh. Signature reads work at every protection level.
- R10: A protection write (`cmd`=10) with `hv_en` high is timed exactly like a byte write. It sets protection bit `addr[1:0]` (values 1 to 3), and value 0 changes nothing. Protection bits are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples `ea_pin` for the latch |
| hv_en | input | 1 | High-voltage programming enable level |
| pgm_stb | input | 1 | Program strobe; its rising edge starts an operation |
| rd_stb | input | 1 | Read request, one cycle per read |
| cmd | input | 2 | 00 write byte, 01 read byte, 10 protection write, 11 signature read |
| addr | input | AW | Byte address, or protection-bit index in bits 1:0 |
| wdata | input | 8 | Byte to program |
| ea_pin | input | 1 | External-access strap input |
| busy_n | output | 1 | Ready (high) / busy (low) |
| rdata | output | 8 | Read result |
| rdata_vld | output | 1 | Read result valid pulse |
| movc_ok | output | 1 | Externally fetched code may read internal code |
| ext_exec_ok | output | 1 | External execution permitted |
| ea_eff | output | 1 | Effective external-access level |

## Verification
A timer that miscounts shows on `busy_n` as a low window that is shorter or longer than WR_CYCLES, measured at the edge where the window closes. A lost pending address or byte shows within two cycles of the next read, as a wrong polling byte or a committed value that reads back wrong. Protection state cannot be read directly. A wrong protection level is therefore exposed by its side effects: one cycle after the bit changes on `movc_ok` and `ext_exec_ok`, or two cycles after a read, through an FFh that should not be there or one that is missing. A reset that clears protection shows immediately on `movc_ok`.

// File: rtl/fprog_pkg.sv
package fprog_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b01,
    CMD_LOCK  = 2'b10,
    CMD_SIG   = 2'b11
  } fp_cmd_e;

  // identification bytes returned for the three signature slots
  function automatic logic [BYTE_W-1:0] sig_byte(input logic [1:0] slot);
    case (slot)
      2'd0:    sig_byte = 8'h1E;
      2'd1:    sig_byte = 8'h87;
      2'd2:    sig_byte = 8'h02;
      default: sig_byte = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/fprog_array.sv
module fprog_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // erased state of the cells
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fprog_timer.sv
module fprog_timer #(
  parameter int CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC - 1);
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/fprog_locks.sv
module fprog_locks (
  input  logic       clk,
  input  logic       set_en,
  input  logic [1:0] set_idx,
  output logic       prog_blk,
  output logic       verify_blk,
  output logic       exec_blk
);
  // sticky: only an array erase (not part of this block) clears them
  logic [3:1] lk = '0;
  logic [3:0] lvl;

  always_ff @(posedge clk) begin
    if (set_en && set_idx != 2'd0) lk[set_idx] <= 1'b1;
  end

  // protection levels are cumulative: a bit counts only if all lower ones are set
  assign lvl[0] = 1'b1;
  assign lvl[1] = lvl[0] & lk[1];
  assign lvl[2] = lvl[1] & lk[2];
  assign lvl[3] = lvl[2] & lk[3];

  assign prog_blk   = lvl[1];
  assign verify_blk = lvl[2];
  assign exec_blk   = lvl[3];
endmodule

// File: rtl/fprog_seq.sv
module fprog_seq
  import fprog_pkg::*;
#(
  parameter int AW        = 10,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_en,
  input  logic              pgm_stb,
  input  logic              rd_stb,
  input  logic [1:0]        cmd,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ea_pin,
  output logic              busy_n,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_vld,
  output logic              movc_ok,
  output logic              ext_exec_ok,
  output logic              ea_eff
);
  localparam logic [AW-3:0] SIG_PAGE = (AW-2)'(8'h30 >> 2);

  logic              stb_q, stb_rise;
  logic              busy, done;
  logic              acc_wr, acc_lk, start;
  logic              op_lock;
  logic [AW-1:0]     pend_addr;
  logic [BYTE_W-1:0] pend_data;
  logic              prog_blk, verify_blk, exec_blk;
  logic [BYTE_W-1:0] ram_q;
  logic              s1_vld, s1_use_ram;
  logic [BYTE_W-1:0] s1_byte;
  logic              ea_lat;

  // strobe edge detection and command acceptance
  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= pgm_stb;
  end

  assign stb_rise = pgm_stb & ~stb_q;
  assign acc_wr   = stb_rise & hv_en & ~busy & (cmd == CMD_WRITE) & ~prog_blk;
  assign acc_lk   = stb_rise & hv_en & ~busy & (cmd == CMD_LOCK);
  assign start    = acc_wr | acc_lk;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_lock   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (start) begin
      op_lock   <= acc_lk;
      pend_addr <= addr;
      pend_data <= wdata;
    end
  end

  fprog_timer #(.CYC(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  fprog_array #(.AW(AW), .DW(BYTE_W)) u_array (
    .clk   (clk),
    .we    (done & ~op_lock),
    .waddr (pend_addr),
    .wdata (pend_data),
    .raddr (addr),
    .rdata (ram_q)
  );

  fprog_locks u_locks (
    .clk        (clk),
    .set_en     (done & op_lock),
    .set_idx    (pend_addr[1:0]),
    .prog_blk   (prog_blk),
    .verify_blk (verify_blk),
    .exec_blk   (exec_blk)
  );

  // read pipeline, stage 1: classify the request
  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= rd_stb & cmd[0];
    if (cmd == CMD_SIG) begin
      s1_use_ram <= 1'b0;
      s1_byte    <= (addr[AW-1:2] == SIG_PAGE) ? sig_byte(addr[1:0]) : 8'hFF;
    end else if (verify_blk) begin
      s1_use_ram <= 1'b0;
      s1_byte    <= 8'hFF;
    end else if (busy && !op_lock && addr == pend_addr) begin
      s1_use_ram <= 1'b0;
      s1_byte    <= {~pend_data[BYTE_W-1], pend_data[BYTE_W-2:0]};
    end else begin
      s1_use_ram <= 1'b1;
      s1_byte    <= 8'hFF;
    end
  end

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) rdata_vld <= 1'b0;
    else     rdata_vld <= s1_vld;
    rdata <= s1_use_ram ? ram_q : s1_byte;
  end

  // external-access latch and permission outputs
  always_ff @(posedge clk) begin
    if (rst) ea_lat <= ea_pin;
    ea_eff      <= (prog_blk && !rst) ? ea_lat : ea_pin;
    movc_ok     <= ~prog_blk;
    ext_exec_ok <= ~exec_blk;
  end

  assign busy_n = ~busy;
endmodule

// File: rtl/fprog_seq_chk.sv
module fprog_seq_chk #(
  parameter int AW        = 10,
  parameter int WR_CYCLES = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          hv_en,
  input logic          pgm_stb,
  input logic          rd_stb,
  input logic [1:0]    cmd,
  input logic [AW-1:0] addr,
  input logic          busy_n,
  input logic          rdata_vld,
  input logic          movc_ok,
  input logic          ext_exec_ok
);
  localparam int BCW = $clog2(WR_CYCLES + 1) + 1;

  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || busy_n) bcnt <= '0;
    else               bcnt <= bcnt + 1'b1;
  end

  AST_WR_START: assert property (@(posedge clk) disable iff (rst)
    (busy_n && $past(busy_n) && hv_en && $rose(pgm_stb) && cmd == 2'b00 && movc_ok) |=> !busy_n); // R1

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && bcnt == BCW'(WR_CYCLES - 1)) |=> busy_n); // R1

  AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && cmd[0]) |=> ##1 rdata_vld); // R2

  AST_NO_HV: assert property (@(posedge clk) disable iff (rst)
    (busy_n && !hv_en) |=> busy_n); // R5

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy_n && !movc_ok && cmd == 2'b00) |=> busy_n); // R6

  AST_LEVEL_ORDER: assert property (@(posedge clk) disable iff (rst)
    !ext_exec_ok |-> !movc_ok); // R8

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !movc_ok |=> !movc_ok); // R10

  wire unused_ok = ^addr;
endmodule

bind fprog_seq fprog_seq_chk #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hv_en       (hv_en),
  .pgm_stb     (pgm_stb),
  .rd_stb      (rd_stb),
  .cmd         (cmd),
  .addr        (addr),
  .busy_n      (busy_n),
  .rdata_vld   (rdata_vld),
  .movc_ok     (movc_ok),
  .ext_exec_ok (ext_exec_ok)
);

// File: tb/fprog_seq_test.sv
module fprog_seq_test;
  localparam int AW = 10;
  localparam int WC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hv_en = 1'b0;
  logic          pgm_stb = 1'b0;
  logic          rd_stb = 1'b0;
  logic [1:0]    cmd = 2'b01;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          ea_pin = 1'b0;
  logic          busy_n, rdata_vld, movc_ok, ext_exec_ok, ea_eff;
  logic [7:0]    rdata;

  fprog_seq #(.AW(AW), .WR_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .hv_en(hv_en), .pgm_stb(pgm_stb), .rd_stb(rd_stb),
    .cmd(cmd), .addr(addr), .wdata(wdata), .ea_pin(ea_pin), .busy_n(busy_n),
    .rdata(rdata), .rdata_vld(rdata_vld), .movc_ok(movc_ok),
    .ext_exec_ok(ext_exec_ok), .ea_eff(ea_eff)
  );

  always #5 clk = ~clk;

  int         n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         run_len = 0, last_len = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for reads, busy window length
  always @(negedge clk) begin
    if (rdata_vld === 1'b1) begin
      if (exp_q.size() == 0) check("R2 unexpected", 32'(rdata), 32'hDEAD);
      else check(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
    if (busy_n === 1'b0) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len  = 0;
    end
  end

  task automatic strobe(logic [1:0] c, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    cmd = c; addr = a; wdata = d; pgm_stb = 1'b1;
    @(negedge clk);
    pgm_stb = 1'b0;
    #1;
  endtask

  task automatic rd(logic [1:0] c, logic [AW-1:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    cmd = c; addr = a; rd_stb = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_ready(string tag);
    while (busy_n !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    check(tag, 32'(last_len), 32'(WC));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 reset busy_n", 32'(busy_n), 1);
    check("R2 reset rdata_vld", 32'(rdata_vld), 0);
    check("R6 reset movc_ok", 32'(movc_ok), 1);
    check("R8 reset ext_exec_ok", 32'(ext_exec_ok), 1);

    ea_pin = 1'b1; idle(2);
    check("R6 ea follows high", 32'(ea_eff), 1);
    ea_pin = 1'b0; idle(2);
    check("R6 ea follows low", 32'(ea_eff), 0);

    hv_en = 1'b1;
    strobe(2'b00, 10'h005, 8'hA5);
    check("R1 busy after strobe", 32'(busy_n), 0);
    rd(2'b01, 10'h005, 8'h25, "R3 poll A5");
    wait_ready("R1 busy length");
    rd(2'b01, 10'h005, 8'hA5, "R3 true data after write");

    strobe(2'b00, 10'h006, 8'h3C);
    strobe(2'b00, 10'h007, 8'h11);
    rd(2'b01, 10'h006, 8'hBC, "R3 poll 3C");
    wait_ready("R4 length kept");
    rd(2'b01, 10'h007, 8'hFF, "R4 ignored byte absent");
    rd(2'b01, 10'h006, 8'h3C, "R2 read back 3C");
    rd(2'b01, 10'h100, 8'hFF, "R2 erased location");

    hv_en = 1'b0;
    strobe(2'b00, 10'h008, 8'h77);
    idle(1);
    check("R5 no start without hv", 32'(busy_n), 1);
    rd(2'b01, 10'h008, 8'hFF, "R5 byte not stored");
    strobe(2'b10, 10'h001, 8'h00);
    idle(3);
    check("R5 lock unchanged without hv", 32'(movc_ok), 1);
    check("R5 busy stays high", 32'(busy_n), 1);
    hv_en = 1'b1;

    rd(2'b11, 10'h030, 8'h1E, "R9 sig 30");
    rd(2'b11, 10'h031, 8'h87, "R9 sig 31");
    rd(2'b11, 10'h032, 8'h02, "R9 sig 32");
    rd(2'b11, 10'h033, 8'hFF, "R9 sig other");

    strobe(2'b10, 10'h000, 8'h00);
    wait_ready("R10 index 0 timed");
    idle(2);
    check("R10 index 0 no effect", 32'(movc_ok), 1);

    strobe(2'b10, 10'h002, 8'h00);
    wait_ready("R10 bit2 timed");
    rd(2'b01, 10'h005, 8'hA5, "R7 bit2 alone no block");

    strobe(2'b10, 10'h001, 8'h00);
    check("R10 lock write busy", 32'(busy_n), 0);
    wait_ready("R10 bit1 timed");
    idle(2);
    check("R6 movc_ok low", 32'(movc_ok), 0);
    check("R8 exec still ok", 32'(ext_exec_ok), 1);
    rd(2'b01, 10'h005, 8'hFF, "R7 verify blocked");
    rd(2'b11, 10'h031, 8'h87, "R9 sig under lock");
    strobe(2'b00, 10'h009, 8'h12);
    idle(1);
    check("R6 locked write ignored", 32'(busy_n), 1);

    ea_pin = 1'b0; rst = 1'b1; idle(2);
    rst = 1'b0; ea_pin = 1'b1; idle(3);
    check("R6 ea latched", 32'(ea_eff), 0);
    check("R10 lock survives reset", 32'(movc_ok), 0);

    strobe(2'b10, 10'h003, 8'h00);
    wait_ready("R10 bit3 timed");
    idle(2);
    check("R8 exec blocked", 32'(ext_exec_ok), 0);

    idle(5);
    check("R2 all reads answered", 32'(exp_q.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule